// File: doc/BRIEF.md
# Time-Locked Periodic Pulse Generator

This block produces two independent pulse trains that are locked to an external time-of-day value made of a seconds part and a nanoseconds part. Each channel holds a target time and a reload period. When the incoming time reaches or passes the target, the channel drives its event output active for a duration chosen from a fixed table by a 4-bit code. If the channel is set to reload, the period is then added to the target, so the next pulse follows one period later.

Software programs the block through a simple 16-bit register write/read port. Every 32-bit seconds value and every 30-bit nanoseconds value is split into two 16-bit halves. A shared configuration register holds, for each channel, the width code, the output polarity and a bit that disables the reload. To stop a channel, software writes its target seconds upper half to all ones, which places the target out of reach, and sets the reload-disable bit.

Top module: `ppo_gen`

## Requirements
- R1: After reset, both channels have target seconds 0xFFFFFFFF, target nanoseconds 0, reload values 0, and the configuration register is 0. Both event outputs rest high, because polarity 0 means active low.
- R2: The register map is selected by address bits [4:3]: 0 is the configuration register at offset 0, 1 is channel 0 and 2 is channel 1. Inside a channel, address bits [2:0] select one of eight registers: 0/1 target ns low/high, 2/3 target seconds low/high, 4/5 reload ns low/high, 6/7 reload seconds low/high. An upper nanoseconds half keeps only bits [13:0] and reads back with bits [15:14] zero. The configuration register reads back as written in bits [11:0].
- R3: A channel fires when the time is greater than or equal to its target, comparing seconds first and then nanoseconds. The event output turns active on the clock edge that follows the first cycle in which the condition holds.
- R4: Configuration bits [7:4] hold the width code of channel 0 and bits [11:8] hold the code of channel 1. Codes 0 to 13 select 100 ns, 500 ns, 1 us, 5 us, 10 us, 50 us, 100 us, 500 us, 1 ms, 5 ms, 10 ms, 50 ms, 100 ms and 200 ms. Codes 14 and 15 select 100 ns. A pulse lasts ceil(width / STEP_NS) clock cycles.
- R5: With reload enabled, each event adds the reload period to the target. The nanoseconds wrap at 1,000,000,000 and carry one into the seconds.
- R6: Configuration bit 0 (channel 0) and bit 2 (channel 1) disable the reload. While a channel's bit is set, it produces one pulse and then stays silent until its target is written again.
- R7: Configuration bit 1 (channel 0) and bit 3 (channel 1) select the polarity: 1 gives an active-high output, 0 gives an active-low output.
- R8: Writing a new target while a pulse is active does not shorten the pulse. The new target is used for the next comparison.
- R9: If a target half is written in the same cycle that the channel fires, the event still fires, the written value is stored, and no reload is applied in that cycle.
- R10: A channel whose target seconds upper half is 0xFFFF produces no pulses while the time stays below it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address, also used for reads |
| wdata | input | 16 | Register write data |
| rd_data | output | 16 | Combinational read data for `addr` |
| tod_sec | input | 32 | Time of day, seconds |
| tod_ns | input | 30 | Time of day, nanoseconds |
| evt_out | output | 2 | Event outputs, one per channel |

## Verification
A software write to a target half and a firing of the same channel can land on one clock edge. In that case the register write and the automatic reload both want to update the target. The bench provokes this by waiting until the time value presented on the next edge equals the target, rounded up to the time step, and then issuing the write of the target nanoseconds low half on exactly that edge. The scoreboard expects three pulses: one at the original target, one at the newly written target, and one a reload period after the written target. It also expects no pulse a reload period after the original target, which is where a design that let the reload win would place one.

// File: rtl/ppo_pkg.sv
package ppo_pkg;

   localparam int NS_W  = 30;
   localparam int SEC_W = 32;
   localparam logic [NS_W-1:0] NS_PER_SEC = 30'd1_000_000_000;

   typedef struct packed {
      logic [SEC_W-1:0] sec;
      logic [NS_W-1:0]  ns;
   } ppo_time_t;

   // register offsets inside one channel window
   localparam logic [2:0] TGT_NS_LO  = 3'd0;
   localparam logic [2:0] TGT_NS_HI  = 3'd1;
   localparam logic [2:0] TGT_SEC_LO = 3'd2;
   localparam logic [2:0] TGT_SEC_HI = 3'd3;
   localparam logic [2:0] RLD_NS_LO  = 3'd4;
   localparam logic [2:0] RLD_NS_HI  = 3'd5;
   localparam logic [2:0] RLD_SEC_LO = 3'd6;
   localparam logic [2:0] RLD_SEC_HI = 3'd7;

   // width code: 100 ns times a power of ten, times five for odd codes;
   // code 13 is 200 ms, codes above 13 fall back to 100 ns
   function automatic logic [NS_W-1:0] code_to_ns(input logic [3:0] code);
      logic [NS_W-1:0] v;
      v = NS_W'(100);
      for (int i = 0; i < 6; i++) begin
         if (i < int'(code[3:1])) v = v * NS_W'(10);
      end
      if (code[0]) v = v * NS_W'(5);
      if (code == 4'd13)     v = NS_W'(200_000_000);
      else if (code > 4'd13) v = NS_W'(100);
      return v;
   endfunction

endpackage

// File: rtl/ppo_width_timer.sv
module ppo_width_timer #(
   parameter int STEP_NS = 5,
   parameter int CNT_W   = 30
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] width_ns,
   output logic             active
);

   localparam logic [CNT_W-1:0] STEP = CNT_W'(STEP_NS);

   logic [CNT_W-1:0] remain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                remain_q <= '0;
      else if (start)            remain_q <= width_ns;
      else if (remain_q > STEP)  remain_q <= remain_q - STEP;
      else                       remain_q <= '0;
   end

   assign active = (remain_q != '0);

   // R4: the remaining time shrinks every cycle until the pulse ends
   assert_pulse_decay_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (remain_q != '0 && !start) |=> (remain_q < $past(remain_q)));

   // R3: a fire turns the output active on the next edge
   assert_fire_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && width_ns != '0) |=> active);

endmodule

// File: rtl/ppo_channel.sv
module ppo_channel
   import ppo_pkg::*;
#(
   parameter int STEP_NS = 5
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [2:0]  reg_sel,
   input  logic [15:0] wdata,
   input  ppo_time_t   tod,
   input  logic        rld_off,
   input  logic [3:0]  width_code,
   output logic [15:0] rd_q,
   output logic        active
);

   ppo_time_t tgt_q, rld_q;
   logic      spent_q;

   logic tgt_wr;
   assign tgt_wr = wr_en && !reg_sel[2];

   // time >= target, seconds first
   logic reached, fire;
   assign reached = (tod.sec > tgt_q.sec) ||
                    ((tod.sec == tgt_q.sec) && (tod.ns >= tgt_q.ns));
   assign fire = reached && !spent_q;

   // next target = target + period with nanosecond wrap
   logic [NS_W:0]    ns_sum;
   logic             ns_wrap;
   ppo_time_t        nxt;
   assign ns_sum  = {1'b0, tgt_q.ns} + {1'b0, rld_q.ns};
   assign ns_wrap = (ns_sum >= {1'b0, NS_PER_SEC});
   assign nxt.ns  = ns_wrap ? NS_W'(ns_sum - {1'b0, NS_PER_SEC}) : ns_sum[NS_W-1:0];
   assign nxt.sec = tgt_q.sec + rld_q.sec + SEC_W'(ns_wrap);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_q.sec <= '1;
         tgt_q.ns  <= '0;
         rld_q     <= '0;
         spent_q   <= 1'b0;
      end else begin
         if (wr_en) begin
            case (reg_sel)
               TGT_NS_LO:  tgt_q.ns[15:0]   <= wdata;
               TGT_NS_HI:  tgt_q.ns[29:16]  <= wdata[13:0];
               TGT_SEC_LO: tgt_q.sec[15:0]  <= wdata;
               TGT_SEC_HI: tgt_q.sec[31:16] <= wdata;
               RLD_NS_LO:  rld_q.ns[15:0]   <= wdata;
               RLD_NS_HI:  rld_q.ns[29:16]  <= wdata[13:0];
               RLD_SEC_LO: rld_q.sec[15:0]  <= wdata;
               default:    rld_q.sec[31:16] <= wdata;
            endcase
         end
         if (tgt_wr) begin
            spent_q <= 1'b0;
         end else if (fire) begin
            if (!rld_off) tgt_q   <= nxt;
            else          spent_q <= 1'b1;
         end
      end
   end

   always_comb begin
      case (reg_sel)
         TGT_NS_LO:  rd_q = tgt_q.ns[15:0];
         TGT_NS_HI:  rd_q = {2'b00, tgt_q.ns[29:16]};
         TGT_SEC_LO: rd_q = tgt_q.sec[15:0];
         TGT_SEC_HI: rd_q = tgt_q.sec[31:16];
         RLD_NS_LO:  rd_q = rld_q.ns[15:0];
         RLD_NS_HI:  rd_q = {2'b00, rld_q.ns[29:16]};
         RLD_SEC_LO: rd_q = rld_q.sec[15:0];
         default:    rd_q = rld_q.sec[31:16];
      endcase
   end

   ppo_width_timer #(.STEP_NS(STEP_NS), .CNT_W(NS_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (fire),
      .width_ns (code_to_ns(width_code)),
      .active   (active)
   );

   // R5: a reload from in-range values leaves the nanoseconds in range
   assert_ns_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !rld_off && !tgt_wr && tgt_q.ns < NS_PER_SEC && rld_q.ns < NS_PER_SEC)
      |=> (tgt_q.ns < NS_PER_SEC));

   // R6: with reload disabled, a fire is not repeated on the next cycle
   assert_single_shot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && rld_off && !tgt_wr) |=> !fire);

endmodule

// File: rtl/ppo_gen.sv
module ppo_gen
   import ppo_pkg::*;
#(
   parameter int STEP_NS = 5,
   parameter int ADDR_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [15:0]       wdata,
   output logic [15:0]       rd_data,
   input  logic [31:0]       tod_sec,
   input  logic [29:0]       tod_ns,
   output logic [1:0]        evt_out
);

   localparam int N_CH  = 2;
   localparam int SEL_W = ADDR_W - 3;
   localparam int CFG_W = 12;

   if (STEP_NS < 1 || STEP_NS > 100) begin : g_bad_step
      $error("STEP_NS must lie in 1..100 so the shortest width spans a cycle");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must be at least 5");
   end

   logic [SEL_W-1:0] blk;
   assign blk = addr[ADDR_W-1:3];

   ppo_time_t tod;
   assign tod.sec = tod_sec;
   assign tod.ns  = tod_ns;

   logic [CFG_W-1:0] cfg_q;
   logic             cfg_wr;
   assign cfg_wr = wr_en && (blk == '0) && (addr[2:0] == 3'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (cfg_wr) cfg_q <= wdata[CFG_W-1:0];
   end

   logic [15:0] ch_rd  [N_CH];
   logic        ch_act [N_CH];

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      logic sel;
      assign sel = (blk == SEL_W'(c + 1));

      ppo_channel #(.STEP_NS(STEP_NS)) u_ch (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_en      (wr_en && sel),
         .reg_sel    (addr[2:0]),
         .wdata      (wdata),
         .tod        (tod),
         .rld_off    (cfg_q[2*c]),
         .width_code (cfg_q[4+4*c +: 4]),
         .rd_q       (ch_rd[c]),
         .active     (ch_act[c])
      );

      assign evt_out[c] = cfg_q[2*c+1] ? ch_act[c] : !ch_act[c];
   end

   always_comb begin
      rd_data = '0;
      if (blk == '0) begin
         if (addr[2:0] == 3'd0) rd_data = 16'(cfg_q);
      end else begin
         for (int c = 0; c < N_CH; c++) begin
            if (blk == SEL_W'(c + 1)) rd_data = ch_rd[c];
         end
      end
   end

   // R2: a configuration write is held from the next edge
   assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (cfg_q == $past(wdata[CFG_W-1:0])));

endmodule

// File: tb/test_ppo_gen.sv
`timescale 1ns/1ps
module test_ppo_gen;

   localparam int STEP = 5;
   localparam longint unsigned NSS = 64'd1000000000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rd_data;
   logic [31:0] tod_sec;
   logic [29:0] tod_ns;
   logic [1:0]  evt;

   always #2.5 clk = ~clk;

   longint unsigned tod_t = 64'd5999990000;
   always @(posedge clk) tod_t <= tod_t + STEP;
   assign tod_sec = 32'(tod_t / NSS);
   assign tod_ns  = 30'(tod_t % NSS);

   ppo_gen #(.STEP_NS(STEP), .ADDR_W(5)) i_ppo_gen (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rd_data(rd_data), .tod_sec(tod_sec), .tod_ns(tod_ns), .evt_out(evt)
   );

   typedef struct {
      longint unsigned t;
      int              len;
      string           req;
   } exp_t;

   exp_t q0[$];
   exp_t q1[$];
   int total = 0;
   int bad = 0;
   logic [1:0] pol_exp = 2'b00;
   bit mon_en = 0;
   bit done = 0;

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int width_cyc(int code);
      int w;
      case (code)
         0: w = 100;        1: w = 500;        2: w = 1000;
         3: w = 5000;       4: w = 10000;      5: w = 50000;
         6: w = 100000;     7: w = 500000;     8: w = 1000000;
         9: w = 5000000;    10: w = 10000000;  11: w = 50000000;
         12: w = 100000000; 13: w = 200000000;
         default: w = 100;
      endcase
      return (w + STEP - 1) / STEP;
   endfunction

   function automatic longint unsigned ceil_step(longint unsigned t);
      return ((t + STEP - 1) / STEP) * STEP;
   endfunction

   // driver side of the scoreboard
   task automatic expect_pulse(int ch, longint unsigned tgt, int code, string req);
      exp_t e;
      e.t   = ceil_step(tgt) + STEP;
      e.len = width_cyc(code);
      e.req = req;
      if (ch == 0) q0.push_back(e);
      else         q1.push_back(e);
   endtask

   // monitor side of the scoreboard
   bit              inp [2];
   longint unsigned st  [2];
   int              ln  [2];

   task automatic finish_pulse(int c);
      exp_t e;
      bit empty;
      empty = (c == 0) ? (q0.size() == 0) : (q1.size() == 0);
      if (empty) begin
         total++;
         bad++;
         $display("FAIL R10 unexpected pulse ch%0d actual=%0d expected=none", c, st[c]);
      end else begin
         if (c == 0) e = q0.pop_front();
         else        e = q1.pop_front();
         chk(st[c] == e.t, e.req, "pulse start time", longint'(st[c]), longint'(e.t));
         chk(ln[c] == e.len, e.req, "pulse length", ln[c], e.len);
      end
   endtask

   always @(negedge clk) begin
      if (mon_en) begin
         for (int c = 0; c < 2; c++) begin
            bit act;
            act = (evt[c] == pol_exp[c]);
            if (act && !inp[c]) begin
               inp[c] = 1'b1; st[c] = tod_t; ln[c] = 1;
            end else if (act) begin
               ln[c]++;
            end else if (inp[c]) begin
               inp[c] = 1'b0;
               finish_pulse(c);
            end
         end
      end
   end

   function automatic logic [4:0] ch_addr(int ch, int off);
      return 5'(8 * (ch + 1) + off);
   endfunction

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [15:0] v);
      @(negedge clk);
      addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic set_cfg(input logic [11:0] v);
      wr(5'd0, {4'b0, v});
      pol_exp = {v[3], v[1]};
   endtask

   task automatic prog_target(int ch, longint unsigned t);
      longint unsigned s, n;
      s = t / NSS;
      n = t % NSS;
      wr(ch_addr(ch, 3), 16'hFFFF);
      wr(ch_addr(ch, 0), 16'(n));
      wr(ch_addr(ch, 1), 16'(n >> 16));
      wr(ch_addr(ch, 2), 16'(s));
      wr(ch_addr(ch, 3), 16'(s >> 16));
   endtask

   task automatic prog_reload(int ch, longint unsigned p);
      wr(ch_addr(ch, 4), 16'(p));
      wr(ch_addr(ch, 5), 16'(p >> 16));
      wr(ch_addr(ch, 6), 16'h0000);
      wr(ch_addr(ch, 7), 16'h0000);
   endtask

   task automatic turn_off(int ch);
      wr(ch_addr(ch, 3), 16'hFFFF);
   endtask

   task automatic wait_until(longint unsigned t);
      while (tod_t < t) @(negedge clk);
   endtask

   initial begin
      logic [15:0] v;
      longint unsigned t, t2, f, s, n;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      mon_en = 1;

      // R1: reset values
      rd(5'd0, v);            chk(v == 16'h0000, "R1", "cfg", v, 0);
      rd(ch_addr(0, 3), v);   chk(v == 16'hFFFF, "R1", "ch0 tgt sec hi", v, 16'hFFFF);
      rd(ch_addr(0, 2), v);   chk(v == 16'hFFFF, "R1", "ch0 tgt sec lo", v, 16'hFFFF);
      rd(ch_addr(0, 0), v);   chk(v == 16'h0000, "R1", "ch0 tgt ns lo", v, 0);
      rd(ch_addr(1, 7), v);   chk(v == 16'h0000, "R1", "ch1 rld sec hi", v, 0);
      chk(evt == 2'b11, "R1", "idle outputs", evt, 3);

      // R2: upper ns half masked to 14 bits, config readback
      wr(ch_addr(1, 1), 16'hFFFF);
      rd(ch_addr(1, 1), v);   chk(v == 16'h3FFF, "R2", "ns hi mask", v, 16'h3FFF);
      wr(ch_addr(1, 1), 16'h0000);
      set_cfg(12'h002);
      rd(5'd0, v);            chk(v == 16'h0002, "R2", "cfg readback", v, 2);
      chk(evt == 2'b10, "R7", "idle levels after polarity", evt, 2);

      // R3/R5/R7: ch0 100 ns pulses every 1 us across a second boundary
      prog_reload(0, 1000);
      t = tod_t + 3000;
      prog_target(0, t);
      for (int k = 0; k < 12; k++)
         expect_pulse(0, t + longint'(k) * 1000, 0, (k == 0) ? "R3" : "R5");
      wait_until(t + 11 * 1000 + 500);
      turn_off(0);
      wait_until(t + 14000);

      // R6: ch1 one shot, 1 us, active low
      set_cfg(12'h206);
      prog_reload(1, 3000);
      t = tod_t + 2000;
      prog_target(1, t);
      expect_pulse(1, t, 2, "R6");
      wait_until(t + 12000);
      turn_off(1);

      // R8: retarget during a 5 us pulse
      set_cfg(12'h30A);
      prog_reload(1, 20000);
      t = tod_t + 2000;
      prog_target(1, t);
      expect_pulse(1, t, 3, "R8");
      wait_until(t + 2500);
      t2 = tod_t + 8000;
      prog_target(1, t2);
      expect_pulse(1, t2, 3, "R8");
      wait_until(t2 + 10000);
      turn_off(1);
      wait_until(t2 + 11000);

      // R9: target write on the very edge the channel fires
      set_cfg(12'h012);
      prog_reload(0, 10000);
      s = tod_t / NSS;
      n = tod_t % NSS;
      t = s * NSS + (((n >> 16) + 2) << 16) + 7;
      prog_target(0, t);
      expect_pulse(0, t, 1, "R9");
      f = ceil_step(t);
      while (tod_t + STEP < f) @(negedge clk);
      wr(ch_addr(0, 0), 16'd4010);
      t2 = t - 7 + 4010;
      expect_pulse(0, t2, 1, "R9");
      expect_pulse(0, t2 + 10000, 1, "R9");
      wait_until(t2 + 15000);
      turn_off(0);

      // R4: code 15 on ch1 and code 4 on ch0 together
      set_cfg(12'hF4F);
      t = tod_t + 1000;
      prog_target(1, t);
      expect_pulse(1, t, 15, "R4");
      t2 = tod_t + 1000;
      prog_target(0, t2);
      expect_pulse(0, t2, 4, "R4");
      wait_until(t2 + 12000);

      // R10: both channels off
      set_cfg(12'h005);
      turn_off(0);
      turn_off(1);
      chk(evt == 2'b11, "R10", "idle after off", evt, 3);
      repeat (2000) @(negedge clk);
      chk(evt == 2'b11, "R10", "still idle", evt, 3);
      chk(q0.size() == 0, "R10", "ch0 missing pulses", q0.size(), 0);
      chk(q1.size() == 0, "R10", "ch1 missing pulses", q1.size(), 0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule